// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Per-Pin Drive Mode

This block groups general-purpose I/O pins into banks of up to eight pins. Each bank is controlled through a small window of byte-wide registers in an 8-bit index space. A host writes a register by presenting an index, a data byte and a write strobe. It reads a register by presenting an index and taking the byte on the read-data port in the same cycle. Each bank has a pin-direction byte, a drive-level byte and a drive-style byte. The drive-style byte picks push-pull or open-drain behaviour for each pin separately. A fourth, read-only byte returns the pad levels after they pass through a two-stage synchronizer.

Banks are laid out downward from index 0xF0 in steps of 0x10. Each bank may have fewer than eight usable pins. The upper bits of a short bank are absent: they read as zero and never drive their pads. The block turns the register contents into a pad output-enable vector and a pad output-value vector, one bit per pin.

Top module: `gpio_multibank`

## Requirements
- R1: During and after reset, every pin is an input, every drive-level bit is 0 and every pin is in open-drain style. As a result, pad_oe and pad_out are all zero and every control register reads 0x00.
- R2: Bank k answers at indices 0xF0 - 16*k through 0xF0 - 16*k + 3. The byte offset selects the register: 0 is direction, 1 is drive level, 2 is pad status and 3 is drive style. A byte written to offset 0, 1 or 3 reads back from the cycle after the write strobe.
- R3: A direction bit of 1 makes the pin an output. A direction bit of 0 makes it an input, and then its pad_oe and pad_out bits are 0.
- R4: For an output pin whose drive-style bit is 1 (push-pull), pad_oe is 1 and pad_out equals the drive-level bit.
- R5: For an output pin whose drive-style bit is 0 (open-drain), pad_oe is the inverse of the drive-level bit and pad_out is 0.
- R6: The pad-status byte returns the pad_in levels as seen two rising clock edges after a change, whatever the direction setting of the pin.
- R7: In a bank with n usable pins, bits n to 7 of every register read as 0 and writes to them have no effect. The matching pad_oe and pad_out bits stay 0.
- R8: Writes to the pad-status offset change nothing. Indices at offsets 4 to 15 of a bank, and indices below the lowest bank, read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 8 | Write data byte |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pad_in | input | NUM_BANKS*8 | Pad levels, bank k in bits 8k+7..8k |
| pad_out | output | NUM_BANKS*8 | Pad output value |
| pad_oe | output | NUM_BANKS*8 | Pad output enable |

## Verification
A register write takes effect on the rising edge that samples the strobe. The bench therefore checks pad_oe, pad_out and the read-back on the following falling edge. Read data is combinational from the index, so each read is sampled one nanosecond after the index is placed at a falling edge. The pad-status byte trails pad_in by exactly two rising edges. The bench changes pad_in at a falling edge and expects the old value after one edge and the new value after the second. Direction, level and style bytes are swept through all 256 patterns in every bank of a configuration with 8, 7, 5 and 4 usable pins. The expected pad vectors are computed from the pin count and the three bytes.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;

    localparam int BYTE_W = 8;

    // Offset inside a bank window (index bits 3:0)
    typedef enum logic [3:0] {
        OFS_DIR  = 4'h0,
        OFS_DOUT = 4'h1,
        OFS_STAT = 4'h2,
        OFS_MODE = 4'h3
    } reg_ofs_e;

    typedef struct packed {
        logic [BYTE_W-1:0] dir;   // 1 = output
        logic [BYTE_W-1:0] dout;  // drive level
        logic [BYTE_W-1:0] mode;  // 1 = push-pull, 0 = open-drain
    } bank_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] oe;
        logic [BYTE_W-1:0] out;
    } pad_drive_t;

    function automatic logic [BYTE_W-1:0] pin_mask(input int n);
        logic [BYTE_W-1:0] m;
        m = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [BYTE_W-1:0] bank_base(input int idx);
        return 8'(8'hF0 - 16 * idx);
    endfunction

    // Push-pull: enable always, level follows data. Open-drain: enable on 0, drive low.
    function automatic pad_drive_t drive_of(input bank_cfg_t c, input logic [BYTE_W-1:0] m);
        pad_drive_t d;
        d.oe  = m & c.dir & (c.mode | ~c.dout);
        d.out = m & c.dir & c.mode & c.dout;
        return d;
    endfunction

endpackage

// File: rtl/gpio_mb_sync.sv
module gpio_mb_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_in;
            stage2 <= stage1;
        end
    end

    assign d_out = stage2;
endmodule

// File: rtl/gpio_mb_bank.sv
module gpio_mb_bank
    import gpio_mb_pkg::*;
#(
    parameter int PINS = 8,
    parameter int IDX  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              we,
    input  logic [BYTE_W-1:0] stat_in,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] pad_oe,
    output logic [BYTE_W-1:0] pad_out
);
    localparam logic [BYTE_W-1:0] MASK = pin_mask(PINS);
    localparam logic [BYTE_W-1:0] BASE = bank_base(IDX);

    bank_cfg_t  cfg;
    pad_drive_t drv;
    logic       hit;
    logic [3:0] ofs;

    assign hit = (addr[7:4] == BASE[7:4]);
    assign ofs = addr[3:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we && hit) begin
            case (ofs)
                OFS_DIR:  cfg.dir  <= wdata & MASK;
                OFS_DOUT: cfg.dout <= wdata & MASK;
                OFS_MODE: cfg.mode <= wdata & MASK;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (ofs)
                OFS_DIR:  rdata = cfg.dir;
                OFS_DOUT: rdata = cfg.dout;
                OFS_STAT: rdata = stat_in & MASK;
                OFS_MODE: rdata = cfg.mode;
                default:  rdata = '0;
            endcase
        end
    end

    assign drv     = drive_of(cfg, MASK);
    assign pad_oe  = drv.oe;
    assign pad_out = drv.out;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && cfg == '0)); // R1

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (we && hit && ofs == OFS_DIR) |=> (cfg.dir == ($past(wdata) & MASK))); // R2

    AST_PP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (we && hit && ofs == OFS_DOUT) |=>
        (((pad_out ^ $past(wdata)) & cfg.dir & cfg.mode & MASK) == '0)); // R4

    AST_STAT_RO: assert property (@(posedge clk) disable iff (rst)
        (we && hit && ofs == OFS_STAT) |=> $stable(cfg)); // R8

    AST_UNUSED_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe | pad_out | rdata) & ~MASK) == '0); // R7
endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
    import gpio_mb_pkg::*;
#(
    parameter int                        NUM_BANKS = 4,
    parameter logic [NUM_BANKS*4-1:0]    BANK_PINS = 16'h4578
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [7:0]                   reg_addr,
    input  logic [7:0]                   reg_wdata,
    input  logic                         reg_we,
    output logic [7:0]                   reg_rdata,
    input  logic [NUM_BANKS*8-1:0]       pad_in,
    output logic [NUM_BANKS*8-1:0]       pad_out,
    output logic [NUM_BANKS*8-1:0]       pad_oe
);
    localparam int PAD_W = NUM_BANKS * BYTE_W;
    localparam int LOW_HI_NIB = 16 - NUM_BANKS;

    logic [PAD_W-1:0]  pad_sync;
    logic [BYTE_W-1:0] bank_rd [NUM_BANKS];

    gpio_mb_sync #(.WIDTH(PAD_W)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pad_in),
        .d_out (pad_sync)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        gpio_mb_bank #(
            .PINS (int'(BANK_PINS[g*4 +: 4])),
            .IDX  (g)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .addr    (reg_addr),
            .wdata   (reg_wdata),
            .we      (reg_we),
            .stat_in (pad_sync[g*BYTE_W +: BYTE_W]),
            .rdata   (bank_rd[g]),
            .pad_oe  (pad_oe[g*BYTE_W +: BYTE_W]),
            .pad_out (pad_out[g*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            reg_rdata = reg_rdata | bank_rd[i];
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((int'(reg_addr[7:4]) < LOW_HI_NIB) || (reg_addr[3:0] > 4'h3)) |->
        (reg_rdata == '0)); // R8
endmodule

// File: tb/gpio_multibank_tb.sv
module gpio_multibank_tb;
    localparam int NB = 4;
    localparam int PW = NB * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_rdata;
    logic [PW-1:0] pad_in = '0;
    logic [PW-1:0] pad_out;
    logic [PW-1:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int   npins  [NB] = '{8, 7, 5, 4};
    logic [7:0] m_dir [NB];
    logic [7:0] m_dout[NB];
    logic [7:0] m_mode[NB];

    always #4 clk = ~clk;

    gpio_multibank #(.NUM_BANKS(NB), .BANK_PINS(16'h4578)) u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] msk(input int b);
        return 8'((1 << npins[b]) - 1);
    endfunction

    function automatic logic [7:0] base(input int b);
        return 8'(240 - 16 * b);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic exp_pads(output logic [PW-1:0] eoe, output logic [PW-1:0] eout);
        eoe = '0; eout = '0;
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < 8; i++) begin
                if (i < npins[b] && m_dir[b][i]) begin
                    if (m_mode[b][i]) begin
                        eoe[b*8+i]  = 1'b1;
                        eout[b*8+i] = m_dout[b][i];
                    end else begin
                        eoe[b*8+i]  = ~m_dout[b][i];
                    end
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]    r;
        logic [PW-1:0] eoe, eout;
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = '0; m_dout[b] = '0; m_mode[b] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1 oe in reset", pad_oe, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after reset", pad_oe, '0);
        chk("R1 out after reset", pad_out, '0);
        for (int b = 0; b < NB; b++) begin
            for (int o = 0; o < 4; o++) begin
                if (o != 2) begin
                    rd(base(b) + 8'(o), r);
                    chk("R1 reg reset value", r, 0);
                end
            end
        end

        // R2 R3 R4 R5: full sweep of the three control bytes per bank
        for (int b = 0; b < NB; b++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] dv, lv, sv;
                dv = 8'(v);
                sv = {dv[3:0], dv[7:4]} ^ 8'h5A;
                lv = ~dv ^ 8'(v << 1);
                wr(base(b) + 8'd0, dv);
                wr(base(b) + 8'd1, lv);
                wr(base(b) + 8'd3, sv);
                m_dir[b] = dv & msk(b);
                m_dout[b] = lv & msk(b);
                m_mode[b] = sv & msk(b);
                exp_pads(eoe, eout);
                chk("R3_R4_R5 pad_oe", pad_oe, eoe);
                chk("R3_R4_R5 pad_out", pad_out, eout);
                rd(base(b) + 8'd0, r); chk("R2 dir readback", r, m_dir[b]);
                rd(base(b) + 8'd1, r); chk("R2 level readback", r, m_dout[b]);
                rd(base(b) + 8'd3, r); chk("R2 style readback", r, m_mode[b]);
            end
        end

        // R7: short bank ignores upper bits
        wr(8'hC0, 8'hFF);
        wr(8'hC3, 8'hFF);
        wr(8'hC1, 8'hFF);
        m_dir[3] = 8'h0F; m_mode[3] = 8'h0F; m_dout[3] = 8'h0F;
        rd(8'hC0, r); chk("R7 short bank dir", r, 8'h0F);
        chk("R7 short bank oe", pad_oe[31:24], 8'h0F);
        chk("R7 short bank out", pad_out[31:24], 8'h0F);

        // R8: status offset read-only, unmapped indices read zero
        exp_pads(eoe, eout);
        wr(8'hE2, 8'h00);
        wr(8'hF2, 8'hFF);
        chk("R8 status write no pad effect", pad_oe, eoe);
        rd(8'hE0, r); chk("R8 status write keeps dir", r, m_dir[1]);
        wr(8'hF5, 8'hFF);
        rd(8'hF5, r); chk("R8 offset 5 reads zero", r, 0);
        wr(8'hB0, 8'hFF);
        rd(8'hB0, r); chk("R8 below lowest bank", r, 0);
        rd(8'h0F, r); chk("R8 index 0x0F", r, 0);
        chk("R8 ignored writes no pad effect", pad_out, eout);

        // R6: status trails pad_in by two edges; outputs do not mask it
        for (int k = 0; k < 24; k++) begin
            logic [PW-1:0] old_in, new_in;
            int b;
            b = k % NB;
            old_in = pad_in;
            new_in = PW'(32'h9E37_79B9 * (k + 1));
            @(negedge clk);
            pad_in = new_in;
            reg_addr = base(b) + 8'd2;
            @(negedge clk);
            rd(base(b) + 8'd2, r);
            chk("R6 status after one edge", r, old_in[b*8 +: 8] & msk(b));
            @(negedge clk);
            rd(base(b) + 8'd2, r);
            chk("R6 status after two edges", r, new_in[b*8 +: 8] & msk(b));
        end

        // R1: reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 oe after second reset", pad_oe, '0);
        rd(8'hF3, r); chk("R1 style after second reset", r, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule